// File: doc/BRIEF.md
# Parallel-Candidate SAD Stereo Disparity Engine

This block turns a rectified stereo pair into a disparity map. Both images enter together as two pixel streams, one pixel of each per clock, in raster order, with a common valid strobe and a strobe that marks the first pixel of a frame. The left image is the reference. For each reference position whose square window lies wholly inside the image, the block compares that window with a set of equally sized windows in the target image. These windows slide leftward along the same row, one column for each disparity step. It then reports the disparity of the closest match.

There is one processing element for each disparity. All of them receive the complete reference window and their own shifted target window in the same cycle. The element costs are a sum of absolute differences over the window. A selector picks the lowest cost, so a new disparity result can leave the block on every clock. Window size, search depth, pixel width and image dimensions are parameters. Rectification and any filtering before or after matching belong to other blocks.

Top module: `sadm_stereo`

## Requirements
- R1: For a reference window whose lower-right pixel is at column c, row r, the cost of disparity d is the sum over the WIN×WIN window of |ref(r−i, c−k) − tar(r−i, c−k−d)|, with i and k each running from 0 to WIN−1.
- R2: `disp_valid` is raised only for input pixels at column ≥ WIN−1 and row ≥ WIN−1 of the current frame, i.e. once a complete window has arrived. Every such pixel yields exactly one result.
- R3: Disparities 0 to MAX_DISP are searched, and `disp` never exceeds MAX_DISP. Costs are held in PIX_W + ceil(log2(WIN·WIN)) bits, so saturated pixel pairs (all 255 against 0) never overflow.
- R4: A candidate whose target window would reach left of column 0 (c − WIN + 1 − d < 0) is given the all-ones cost and can never be chosen.
- R5: `disp` is the disparity with the lowest cost among the candidates.
- R6: When several candidates share the lowest cost, the smallest disparity is reported.
- R7: The result for a pixel accepted at clock edge k appears on the outputs after edge k+2. Cycles without valid input produce cycles without valid output, so gaps in the input stream pass through unchanged.
- R8: A pixel presented with `frame_start` is taken as column 0, row 0 of a new frame, even when the previous frame was cut short.
- R9: While reset is asserted and right after it, `disp_valid` is 0 and `disp` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Both pixel inputs carry a pixel this cycle |
| frame_start | input | 1 | With pix_valid: this pixel is the first of a frame |
| ref_pix | input | PIX_W | Reference (left) image pixel |
| tar_pix | input | PIX_W | Target (right) image pixel |
| disp_valid | output | 1 | `disp` holds a new result |
| disp | output | clog2(MAX_DISP+1) | Disparity of the best-matching candidate |

## Verification
The hardest outcome to reach from the ports is an exact cost tie between candidates, together with the exclusion of windows that hang off the left edge. Random texture almost never produces either. The stimulus therefore includes a frame made of columns that alternate with period two, which makes every even disparity cost exactly zero. It also includes a frame whose true shift equals the largest disparity, so the first columns of each row must settle on a smaller candidate. A frame cut off mid-row and followed by a fresh frame strobe checks that the position count restarts. A frame with input bubbles checks that gaps reach the output at the fixed latency.

// File: rtl/sadm_pkg.sv
package sadm_pkg;

    // Width that holds the sum of n absolute differences of pix_w-bit pixels
    function automatic int sum_width(input int pix_w, input int n);
        return pix_w + $clog2(n);
    endfunction

    // Largest cost a real (in-image) candidate can reach
    function automatic int max_real_cost(input int pix_w, input int n);
        return n * ((1 << pix_w) - 1);
    endfunction

endpackage

// File: rtl/sadm_linebuf.sv
module sadm_linebuf #(
    parameter int PIX_W  = 8,
    parameter int LINE_W = 16,
    parameter int TAPS   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic [PIX_W-1:0]            din,
    output logic [TAPS-1:0][PIX_W-1:0]  taps
);
    localparam int DEPTH = LINE_W * TAPS;

    logic [DEPTH-1:0][PIX_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (shift_en) begin
            mem_d[0] = din;
            for (int j = 1; j < DEPTH; j++) begin
                mem_d[j] = mem_q[j-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    // Tap t holds the pixel of the same column, t+1 rows above the input
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign taps[t] = mem_q[(t+1)*LINE_W-1];
    end
endmodule

// File: rtl/sadm_pe.sv
module sadm_pe #(
    parameter int PIX_W = 8,
    parameter int WIN   = 3,
    parameter int CW    = 12
) (
    input  logic [WIN-1:0][WIN-1:0][PIX_W-1:0] ref_win,
    input  logic [WIN-1:0][WIN-1:0][PIX_W-1:0] tar_win,
    input  logic                               cand_ok,
    output logic [CW-1:0]                      cost
);
    logic [CW-1:0]    acc;
    logic [PIX_W-1:0] diff;

    always_comb begin
        acc  = '0;
        diff = '0;
        for (int i = 0; i < WIN; i++) begin
            for (int k = 0; k < WIN; k++) begin
                diff = (ref_win[i][k] > tar_win[i][k]) ? (ref_win[i][k] - tar_win[i][k])
                                                       : (tar_win[i][k] - ref_win[i][k]);
                acc  = acc + CW'(diff);
            end
        end
        cost = cand_ok ? acc : '1;
    end
endmodule

// File: rtl/sadm_argmin.sv
module sadm_argmin #(
    parameter int NUM = 5,
    parameter int CW  = 12,
    parameter int IW  = 3
) (
    input  logic [NUM-1:0][CW-1:0] costs,
    output logic [IW-1:0]          idx
);
    logic [CW-1:0] best;

    // Strict less-than while scanning upward keeps the lower index on ties
    always_comb begin
        best = costs[0];
        idx  = '0;
        for (int d = 1; d < NUM; d++) begin
            if (costs[d] < best) begin
                best = costs[d];
                idx  = IW'(d);
            end
        end
    end
endmodule

// File: rtl/sadm_stereo.sv
module sadm_stereo #(
    parameter int PIX_W    = 8,
    parameter int WIN      = 3,
    parameter int MAX_DISP = 4,
    parameter int IMG_W    = 16,
    parameter int IMG_H    = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            pix_valid,
    input  logic                            frame_start,
    input  logic [PIX_W-1:0]                ref_pix,
    input  logic [PIX_W-1:0]                tar_pix,
    output logic                            disp_valid,
    output logic [$clog2(MAX_DISP+1)-1:0]   disp
);
    import sadm_pkg::*;

    localparam int NUM_D  = MAX_DISP + 1;
    localparam int DISP_W = $clog2(NUM_D);
    localparam int CW     = sum_width(PIX_W, WIN * WIN);
    localparam int TW     = WIN + MAX_DISP;
    localparam int TAPS   = WIN - 1;
    localparam int COL_W  = $clog2(IMG_W);
    localparam int ROW_W  = $clog2(IMG_H);

    typedef struct packed {
        logic [COL_W-1:0]                    col;
        logic [ROW_W-1:0]                    row;
        logic [WIN-1:0][WIN-1:0][PIX_W-1:0]  rwin;
        logic [WIN-1:0][TW-1:0][PIX_W-1:0]   twin;
        logic [NUM_D-1:0]                    cok;
        logic                                s1_vld;
        logic [NUM_D-1:0][CW-1:0]            cost;
        logic                                s2_vld;
        logic [DISP_W-1:0]                   disp;
        logic                                s3_vld;
    } state_t;

    state_t s_d, s_q;

    // Line buffers, one per image (0 = reference, 1 = target)
    logic [1:0][PIX_W-1:0]                lb_in;
    logic [1:0][TAPS-1:0][PIX_W-1:0]      lb_tap;
    logic [1:0][WIN-1:0][PIX_W-1:0]       colv;

    assign lb_in[0] = ref_pix;
    assign lb_in[1] = tar_pix;

    for (genvar g = 0; g < 2; g++) begin : g_img
        sadm_linebuf #(
            .PIX_W (PIX_W),
            .LINE_W(IMG_W),
            .TAPS  (TAPS)
        ) u_lb (
            .clk     (clk),
            .rst_n   (rst_n),
            .shift_en(pix_valid),
            .din     (lb_in[g]),
            .taps    (lb_tap[g])
        );
        // Column vector: entry 0 is the current row, entry i is i rows above
        assign colv[g][0] = lb_in[g];
        for (genvar i = 1; i < WIN; i++) begin : g_col
            assign colv[g][i] = lb_tap[g][i-1];
        end
    end

    // Shifted target windows, one per candidate disparity
    logic [NUM_D-1:0][WIN-1:0][WIN-1:0][PIX_W-1:0] tslice;
    logic [NUM_D-1:0][CW-1:0]                      pe_cost;
    logic [DISP_W-1:0]                             min_idx;

    for (genvar d = 0; d < NUM_D; d++) begin : g_pe
        for (genvar i = 0; i < WIN; i++) begin : g_r
            for (genvar k = 0; k < WIN; k++) begin : g_c
                assign tslice[d][i][k] = s_q.twin[i][k+d];
            end
        end
        sadm_pe #(
            .PIX_W(PIX_W),
            .WIN  (WIN),
            .CW   (CW)
        ) u_pe (
            .ref_win(s_q.rwin),
            .tar_win(tslice[d]),
            .cand_ok(s_q.cok[d]),
            .cost   (pe_cost[d])
        );
    end

    sadm_argmin #(
        .NUM(NUM_D),
        .CW (CW),
        .IW (DISP_W)
    ) u_min (
        .costs(s_q.cost),
        .idx  (min_idx)
    );

    logic [COL_W-1:0] pcol;
    logic [ROW_W-1:0] prow;

    always_comb begin
        s_d  = s_q;
        pcol = frame_start ? '0 : s_q.col;
        prow = frame_start ? '0 : s_q.row;
        s_d.s1_vld = 1'b0;
        if (pix_valid) begin
            for (int i = 0; i < WIN; i++) begin
                s_d.rwin[i][0] = colv[0][i];
                for (int k = 1; k < WIN; k++) begin
                    s_d.rwin[i][k] = s_q.rwin[i][k-1];
                end
                s_d.twin[i][0] = colv[1][i];
                for (int k = 1; k < TW; k++) begin
                    s_d.twin[i][k] = s_q.twin[i][k-1];
                end
            end
            for (int d = 0; d < NUM_D; d++) begin
                s_d.cok[d] = (int'(pcol) >= WIN - 1 + d);
            end
            s_d.s1_vld = (int'(prow) >= WIN - 1) && (int'(pcol) >= WIN - 1);
            if (int'(pcol) == IMG_W - 1) begin
                s_d.col = '0;
                s_d.row = (int'(prow) == IMG_H - 1) ? '0 : prow + 1'b1;
            end else begin
                s_d.col = pcol + 1'b1;
                s_d.row = prow;
            end
        end
        s_d.cost   = pe_cost;
        s_d.s2_vld = s_q.s1_vld;
        s_d.disp   = min_idx;
        s_d.s3_vld = s_q.s2_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign disp_valid = s_q.s3_vld;
    assign disp       = s_q.disp;

    // Registered candidate costs, brought out for the bound checker
    logic [NUM_D*CW-1:0] cost_flat;
    assign cost_flat = s_q.cost;
endmodule

// File: rtl/sadm_checker.sv
module sadm_checker #(
    parameter int PIX_W    = 8,
    parameter int WIN      = 3,
    parameter int MAX_DISP = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           pix_valid,
    input logic                           disp_valid,
    input logic [$clog2(MAX_DISP+1)-1:0]  disp,
    input logic [(MAX_DISP+1)*(PIX_W+$clog2(WIN*WIN))-1:0] cost_flat
);
    import sadm_pkg::*;

    localparam int NUM_D   = MAX_DISP + 1;
    localparam int CW      = sum_width(PIX_W, WIN * WIN);
    localparam int MAXREAL = max_real_cost(PIX_W, WIN * WIN);

    logic [NUM_D-1:0][CW-1:0] prev_q;
    logic [CW-1:0]            sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= cost_flat;
        end
    end

    always_comb begin
        sel = '1;
        for (int d = 0; d < NUM_D; d++) begin
            if (d == int'(disp)) sel = prev_q[d];
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !disp_valid); // R9

    AST_DISP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> int'(disp) <= MAX_DISP); // R3

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> $past(pix_valid, 3)); // R7

    for (genvar d = 0; d < NUM_D; d++) begin : g_chk
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(cost_flat[d*CW +: CW]) <= MAXREAL) || (cost_flat[d*CW +: CW] == '1)); // R3

        AST_MIN_CHOSEN: assert property (@(posedge clk) disable iff (!rst_n)
            disp_valid |-> prev_q[d] >= sel); // R5

        AST_TIE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_valid && (d < int'(disp))) |-> prev_q[d] > sel); // R6
    end
endmodule

bind sadm_stereo sadm_checker #(
    .PIX_W   (PIX_W),
    .WIN     (WIN),
    .MAX_DISP(MAX_DISP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .disp_valid(disp_valid),
    .disp      (disp),
    .cost_flat (cost_flat)
);

// File: tb/sadm_stereo_bench.sv
module sadm_stereo_bench;
    localparam int PW = 8;
    localparam int W  = 3;
    localparam int D  = 4;
    localparam int IW = 16;
    localparam int IH = 8;
    localparam int DW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_valid = 1'b0;
    logic          frame_start = 1'b0;
    logic [PW-1:0] ref_pix = '0;
    logic [PW-1:0] tar_pix = '0;
    logic          disp_valid;
    logic [DW-1:0] disp;

    always #4 clk = ~clk;

    sadm_stereo #(
        .PIX_W(PW), .WIN(W), .MAX_DISP(D), .IMG_W(IW), .IMG_H(IH)
    ) u_sadm_stereo (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .frame_start(frame_start),
        .ref_pix(ref_pix), .tar_pix(tar_pix), .disp_valid(disp_valid), .disp(disp)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    string tag = "R9";

    int rimg [IH][IW];
    int timg [IH][IW];
    int mcol = 0, mrow = 0;
    int m0v = 0, m0d = 0, m1v = 0, m1d = 0, mov = 0, mod = 0;

    function automatic int hsh(int seed, int r, int c);
        return ((r * 131 + c * 71 + seed * 29) ^ (c * c * 7 + r * r * 3 + seed)) & 255;
    endfunction

    task automatic compare();
        n_cmp++;
        if (disp_valid !== 1'(mov)) begin
            n_bad++;
            $display("FAIL R2 (%s): disp_valid=%0b expected %0b", tag, disp_valid, mov);
        end else if (mov != 0 && int'(disp) != mod) begin
            n_bad++;
            $display("FAIL %s: disp=%0d expected %0d", tag, disp, mod);
        end
    endtask

    // Behavioural reference: place pixel, then search every disparity over whole window
    task automatic model_push(input bit v, input bit fs, input int rp, input int tp);
        int nv = 0, nd = 0;
        if (v) begin
            int c = fs ? 0 : mcol;
            int r = fs ? 0 : mrow;
            rimg[r][c] = rp;
            timg[r][c] = tp;
            mcol = (c == IW - 1) ? 0 : c + 1;
            mrow = (c == IW - 1) ? ((r == IH - 1) ? 0 : r + 1) : r;
            if (r >= W - 1 && c >= W - 1) begin
                int best = -1;
                nv = 1;
                for (int d = 0; d <= D; d++) begin
                    if (c >= W - 1 + d) begin
                        int cost = 0;
                        for (int i = 0; i < W; i++) begin
                            for (int k = 0; k < W; k++) begin
                                int a = rimg[r-i][c-k];
                                int b = timg[r-i][c-k-d];
                                cost += (a > b) ? a - b : b - a;
                            end
                        end
                        if (best < 0 || cost < best) begin
                            best = cost;
                            nd   = d;
                        end
                    end
                end
            end
        end
        mov = m1v; mod = m1d;
        m1v = m0v; m1d = m0d;
        m0v = nv;  m0d = nd;
    endtask

    task automatic step(input bit v, input bit fs, input int rp, input int tp);
        @(negedge clk);
        compare();
        pix_valid   = v;
        frame_start = fs;
        ref_pix     = PW'(rp);
        tar_pix     = PW'(tp);
        model_push(v, fs, rp, tp);
    endtask

    task automatic gen(input int kind, input int seed, input int r, input int c,
                       output int rp, output int tp);
        case (kind)
            0: begin rp = hsh(seed, r, c); tp = hsh(seed, r, c + (r % (D + 1))); end // shift per row
            1: begin rp = (c % 2) * 200;   tp = (c % 2) * 200; end                  // exact ties
            2: begin rp = 255;             tp = (c % 4 == 3) ? 255 : 0; end          // saturation
            3: begin rp = hsh(seed, r, c); tp = hsh(seed + 7, r, c); end             // unrelated
            default: begin rp = hsh(seed, r, c); tp = hsh(seed, r, c + D); end       // left edge
        endcase
    endtask

    task automatic send_frame(input int kind, input int seed, input int npix, input bit bubbles);
        for (int p = 0; p < npix; p++) begin
            int rp, tp;
            gen(kind, seed, p / IW, p % IW, rp, tp);
            step(1'b1, p == 0, rp, tp);
            if (bubbles && (p % 3 == 1)) begin
                for (int b = 0; b <= (p % 2); b++) step(1'b0, 1'b0, 0, 0);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        repeat (198000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        finish_run();
    end

    initial begin
        // R9: outputs quiet under reset
        repeat (3) step(1'b0, 1'b0, 0, 0);
        n_cmp++;
        if (disp_valid !== 1'b0 || disp !== '0) begin
            n_bad++;
            $display("FAIL R9: valid=%0b disp=%0d expected 0 0", disp_valid, disp);
        end
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) step(1'b0, 1'b0, 0, 0);

        tag = "R1";  send_frame(0, 1, IW * IH, 1'b0);
        tag = "R4";  send_frame(4, 2, IW * IH, 1'b0);
        tag = "R6";  send_frame(1, 0, IW * IH, 1'b0);
        tag = "R3";  send_frame(2, 0, IW * IH, 1'b0);
        tag = "R5";  send_frame(3, 3, IW * IH, 1'b0);
        tag = "R7";  send_frame(0, 5, IW * IH, 1'b1);
        tag = "R8";  send_frame(0, 9, 2 * IW + 7, 1'b0);
        send_frame(3, 11, IW * IH, 1'b0);
        repeat (6) step(1'b0, 1'b0, 0, 0);
        finish_run();
    end
endmodule